// File: doc/BRIEF.md
# Request tag association queue

This block sits on the user side of a PCIe requester port. Each time the user logic hands a non-posted request to the core, the block stores the user's own identifier for that request. The core later returns one tag per request, in the order the requests were sent. The block pairs each returned tag with the oldest identifier still waiting and emits the pair, so downstream logic can match later completions to its own bookkeeping.

Requests enter on a valid/ready interface with up to two lanes. When straddling is enabled, two requests may be accepted in one cycle; lane 0 holds the earlier one. Ready is granted only when the queue has room for the largest transfer the current mode allows, so a request is never accepted and then lost. Tags come back on two lanes that have no ready signal, because the core cannot be stalled. The paired results are therefore registered outputs with no back-pressure. A sticky error flag reports tag traffic that breaks the lane rules or that has no outstanding request to pair with.

Top module: `rqtag_assoc_q`

## Requirements
- R1: Each valid tag on lane 0 in cycle N, with at least one entry outstanding, produces pair_vld0 in cycle N+1. pair_id0 is the oldest outstanding identifier and pair_tag0 is the tag. Identifiers are consumed strictly first-in first-out.
- R2: When both tag lanes are valid with straddling enabled and at least two entries outstanding, lane 0 pairs with the oldest identifier and lane 1 with the next oldest. Both pairs appear in the same cycle. pair_vld1 is never high without pair_vld0.
- R3: A request on lane 0 is accepted when req_vld0 and req_rdy are both high. Lane 1 is accepted only if lane 0 is accepted in the same cycle and straddle_en is 1. Otherwise req_vld1 is ignored and occupancy does not count it.
- R4: req_rdy is high exactly when at least 2 entries are free (straddle_en=1) or at least 1 entry is free (straddle_en=0). Requests presented while req_rdy is low are ignored.
- R5: occupancy equals accepted requests minus paired tags since reset. full is high when occupancy equals DEPTH, and empty is high when occupancy is 0.
- R6: An accept of up to two requests and a pairing of up to two tags in the same cycle both take effect. Identifiers accepted in a cycle cannot be paired in that same cycle.
- R7: A lane 0 tag while nothing is outstanding, or a tag on both lanes while fewer than two entries are outstanding, sets proto_err. A lane with no entry to pair produces no pair.
- R8: A lane 1 tag without a lane 0 tag, or any lane 1 tag while straddle_en is 0, sets proto_err. That lane 1 tag is ignored.
- R9: proto_err stays high until reset. A synchronous active-high reset clears the queue, occupancy, proto_err and both pair outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| straddle_en | input | 1 | Enables two requests and two tags per cycle |
| req_vld0 | input | 1 | Request lane 0 valid (earlier request) |
| req_id0 | input | ID_W | User identifier, lane 0 |
| req_vld1 | input | 1 | Request lane 1 valid (later request) |
| req_id1 | input | ID_W | User identifier, lane 1 |
| req_rdy | output | 1 | Room for the largest transfer allowed in the current mode |
| tag_vld0 | input | 1 | Tag lane 0 valid |
| tag_val0 | input | TAG_W | Tag, lane 0 (earlier request) |
| tag_vld1 | input | 1 | Tag lane 1 valid |
| tag_val1 | input | TAG_W | Tag, lane 1 (later request) |
| pair_vld0 | output | 1 | Pair lane 0 valid |
| pair_id0 | output | ID_W | Identifier of pair lane 0 |
| pair_tag0 | output | TAG_W | Tag of pair lane 0 |
| pair_vld1 | output | 1 | Pair lane 1 valid |
| pair_id1 | output | ID_W | Identifier of pair lane 1 |
| pair_tag1 | output | TAG_W | Tag of pair lane 1 |
| occupancy | output | $clog2(DEPTH+1) | Outstanding entries |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| proto_err | output | 1 | Sticky lane-rule or underflow error |

## Verification
The bench builds the block with DEPTH=8, ID_W=8 and TAG_W=8. The shallow depth lets a few double pushes fill the queue, so ready withdrawal in both modes and pointer wraparound are covered with mixed single and double traffic. The 8-bit identifiers and tags make each scoreboard pair distinct, so any reordering between lanes or across the wrap shows up as a mismatch.

// File: rtl/rqtag_pkg.sv
package rqtag_pkg;
  typedef logic [1:0] lane_cnt_t;

  function automatic lane_cnt_t lanes_used(input logic a, input logic b);
    return lane_cnt_t'({1'b0, a}) + lane_cnt_t'({1'b0, b});
  endfunction
endpackage

// File: rtl/rqtag_lane_ctl.sv
module rqtag_lane_ctl #(
  parameter int CNT_W = 6
) (
  input  logic             straddle_en,
  input  logic             req_vld0,
  input  logic             req_vld1,
  input  logic             req_rdy,
  input  logic             tag_vld0,
  input  logic             tag_vld1,
  input  logic [CNT_W-1:0] occ,
  output logic             push0,
  output logic             push1,
  output logic             pop0,
  output logic             pop1,
  output logic             err_evt
);
  logic have_one, have_two, lane1_legal;

  always_comb begin
    have_one    = (occ != '0);
    have_two    = (occ >= CNT_W'(2));
    lane1_legal = tag_vld0 && straddle_en;

    push0 = req_vld0 && req_rdy;
    push1 = push0 && req_vld1 && straddle_en;

    pop0 = tag_vld0 && have_one;
    pop1 = tag_vld1 && lane1_legal && have_two;

    err_evt = (tag_vld0 && !have_one)
            || (tag_vld1 && !lane1_legal)
            || (tag_vld1 && lane1_legal && !have_two);
  end
endmodule

// File: rtl/rqtag_store.sv
module rqtag_store #(
  parameter int DEPTH = 32,  // power of two, at least 2
  parameter int ID_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push0,
  input  logic             push1,
  input  logic [ID_W-1:0]  id0,
  input  logic [ID_W-1:0]  id1,
  input  logic             pop0,
  input  logic             pop1,
  output logic [ID_W-1:0]  head0,
  output logic [ID_W-1:0]  head1,
  output logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             empty
);
  import rqtag_pkg::*;

  logic [ID_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q, wp_nx1, rp_nx1;
  logic [CNT_W-1:0] occ_q;
  lane_cnt_t        n_in, n_out;

  always_comb begin
    wp_nx1 = wp_q + PTR_W'(1);
    rp_nx1 = rp_q + PTR_W'(1);
    n_in   = lanes_used(push0, push1);
    n_out  = lanes_used(pop0, pop1);
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (push0 && wp_q == PTR_W'(e)) mem[e] <= id0;
      else if (push1 && wp_nx1 == PTR_W'(e)) mem[e] <= id1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      wp_q  <= wp_q + PTR_W'(n_in);
      rp_q  <= rp_q + PTR_W'(n_out);
      occ_q <= occ_q + CNT_W'(n_in) - CNT_W'(n_out);
    end
  end

  assign head0 = mem[rp_q];
  assign head1 = mem[rp_nx1];
  assign occ   = occ_q;
  assign full  = (occ_q == CNT_W'(DEPTH));
  assign empty = (occ_q == '0);

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ_q <= CNT_W'(DEPTH));

  // R4
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !pop0) |=> (occ_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/rqtag_pair_reg.sv
module rqtag_pair_reg #(
  parameter int ID_W  = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [ID_W-1:0]  id_in,
  input  logic [TAG_W-1:0] tag_in,
  output logic             vld_q,
  output logic [ID_W-1:0]  id_q,
  output logic [TAG_W-1:0] tag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      id_q  <= '0;
      tag_q <= '0;
    end else begin
      vld_q <= take;
      if (take) begin
        id_q  <= id_in;
        tag_q <= tag_in;
      end
    end
  end
endmodule

// File: rtl/rqtag_assoc_q.sv
module rqtag_assoc_q #(
  parameter int DEPTH = 32,
  parameter int ID_W  = 8,
  parameter int TAG_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             straddle_en,
  input  logic             req_vld0,
  input  logic [ID_W-1:0]  req_id0,
  input  logic             req_vld1,
  input  logic [ID_W-1:0]  req_id1,
  output logic             req_rdy,
  input  logic             tag_vld0,
  input  logic [TAG_W-1:0] tag_val0,
  input  logic             tag_vld1,
  input  logic [TAG_W-1:0] tag_val1,
  output logic             pair_vld0,
  output logic [ID_W-1:0]  pair_id0,
  output logic [TAG_W-1:0] pair_tag0,
  output logic             pair_vld1,
  output logic [ID_W-1:0]  pair_id1,
  output logic [TAG_W-1:0] pair_tag1,
  output logic [CNT_W-1:0] occupancy,
  output logic             full,
  output logic             empty,
  output logic             proto_err
);
  localparam logic [CNT_W-1:0] LIM_TWO = CNT_W'(DEPTH - 2);
  localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(DEPTH - 1);

  logic             push0, push1, pop0, pop1, err_evt, err_q;
  logic [ID_W-1:0]  head0, head1;
  logic [CNT_W-1:0] occ;

  logic             ln_take [2];
  logic [ID_W-1:0]  ln_id   [2];
  logic [TAG_W-1:0] ln_tag  [2];
  logic             ln_vld  [2];
  logic [ID_W-1:0]  ln_oid  [2];
  logic [TAG_W-1:0] ln_otag [2];

  assign req_rdy = straddle_en ? (occ <= LIM_TWO) : (occ <= LIM_ONE);

  rqtag_lane_ctl #(.CNT_W(CNT_W)) ctl_i (
    .straddle_en(straddle_en), .req_vld0(req_vld0), .req_vld1(req_vld1),
    .req_rdy(req_rdy), .tag_vld0(tag_vld0), .tag_vld1(tag_vld1), .occ(occ),
    .push0(push0), .push1(push1), .pop0(pop0), .pop1(pop1), .err_evt(err_evt)
  );

  rqtag_store #(.DEPTH(DEPTH), .ID_W(ID_W)) store_i (
    .clk(clk), .rst(rst), .push0(push0), .push1(push1),
    .id0(req_id0), .id1(req_id1), .pop0(pop0), .pop1(pop1),
    .head0(head0), .head1(head1), .occ(occ), .full(full), .empty(empty)
  );

  assign ln_take[0] = pop0;
  assign ln_take[1] = pop1;
  assign ln_id[0]   = head0;
  assign ln_id[1]   = head1;
  assign ln_tag[0]  = tag_val0;
  assign ln_tag[1]  = tag_val1;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    rqtag_pair_reg #(.ID_W(ID_W), .TAG_W(TAG_W)) pr_i (
      .clk(clk), .rst(rst), .take(ln_take[l]), .id_in(ln_id[l]),
      .tag_in(ln_tag[l]), .vld_q(ln_vld[l]), .id_q(ln_oid[l]),
      .tag_q(ln_otag[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if (err_evt) err_q <= 1'b1;
  end

  assign pair_vld0 = ln_vld[0];
  assign pair_id0  = ln_oid[0];
  assign pair_tag0 = ln_otag[0];
  assign pair_vld1 = ln_vld[1];
  assign pair_id1  = ln_oid[1];
  assign pair_tag1 = ln_otag[1];
  assign occupancy = occ;
  assign proto_err = err_q;

  // R1
  pair_src_chk: assert property (@(posedge clk) disable iff (rst)
    pair_vld0 |-> $past(tag_vld0));

  // R2
  lane_order_chk: assert property (@(posedge clk) disable iff (rst)
    pair_vld1 |-> pair_vld0);

  // R4
  rdy_full_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !req_rdy);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

// File: tb/rqtag_assoc_q_tb_top.sv
module rqtag_assoc_q_tb_top;
  localparam int DEPTH = 8;
  localparam int ID_W  = 8;
  localparam int TAG_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic straddle_en = 1'b1;
  logic req_vld0 = 0, req_vld1 = 0, tag_vld0 = 0, tag_vld1 = 0;
  logic [ID_W-1:0]  req_id0 = '0, req_id1 = '0;
  logic [TAG_W-1:0] tag_val0 = '0, tag_val1 = '0;
  logic req_rdy, pair_vld0, pair_vld1, full, empty, proto_err;
  logic [ID_W-1:0]  pair_id0, pair_id1;
  logic [TAG_W-1:0] pair_tag0, pair_tag1;
  logic [CNT_W-1:0] occupancy;

  always #2 clk = ~clk;

  rqtag_assoc_q #(.DEPTH(DEPTH), .ID_W(ID_W), .TAG_W(TAG_W)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit merr = 0;
  logic [ID_W-1:0] mq[$];
  logic [15:0] exp0[$], exp1[$];

  task automatic check(string req, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // monitor: R1 lane 0, R2 lane 1
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (pair_vld0) begin
        if (exp0.size() == 0) check("R1 unexpected lane0 pair", 1, 0);
        else check("R1 lane0 pair", {pair_id0, pair_tag0}, exp0.pop_front());
      end
      if (pair_vld1) begin
        if (exp1.size() == 0) check("R2 unexpected lane1 pair", 1, 0);
        else check("R2 lane1 pair", {pair_id1, pair_tag1}, exp1.pop_front());
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    {req_vld0, req_vld1, tag_vld0, tag_vld1} = '0;
    repeat (3) @(negedge clk);
    mq.delete(); exp0.delete(); exp1.delete(); merr = 0;
    rst = 1'b0;
  endtask

  // driver: one cycle of stimulus plus model update
  task automatic cyc(bit rv0, int id0, bit rv1, int id1,
                     bit tv0, int t0, bit tv1, int t1);
    int sz = mq.size();
    bit rdy_m = straddle_en ? (DEPTH - sz >= 2) : (DEPTH - sz >= 1);
    bit ok1 = tv0 && straddle_en;
    req_vld0 = rv0; req_id0 = ID_W'(id0); req_vld1 = rv1; req_id1 = ID_W'(id1);
    tag_vld0 = tv0; tag_val0 = TAG_W'(t0); tag_vld1 = tv1; tag_val1 = TAG_W'(t1);
    #0.5;
    check("R4 req_rdy", req_rdy, rdy_m);
    if (tv0 && sz < 1) merr = 1;
    if (tv1 && !ok1) merr = 1;
    if (tv1 && ok1 && sz < 2) merr = 1;
    if (tv0 && sz >= 1) exp0.push_back({mq.pop_front(), TAG_W'(t0)});
    if (tv1 && ok1 && sz >= 2) exp1.push_back({mq.pop_front(), TAG_W'(t1)});
    if (rv0 && rdy_m) begin
      mq.push_back(ID_W'(id0));
      if (rv1 && straddle_en) mq.push_back(ID_W'(id1));
    end
    @(negedge clk);
    check("R5 occupancy", occupancy, mq.size());
    check("R7/R8 proto_err", proto_err, merr);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state
    check("R9 occupancy", occupancy, 0);
    check("R9 empty", empty, 1);
    check("R9 full", full, 0);
    check("R9 proto_err", proto_err, 0);
    check("R9 pair_vld0", pair_vld0, 0);

    // R1 single pushes then single tag
    cyc(1, 'h11, 0, 0, 0, 0, 0, 0);
    cyc(1, 'h22, 0, 0, 0, 0, 0, 0);
    cyc(1, 'h33, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 'hA0, 0, 0);
    // R6 R2 double push with double pop
    cyc(1, 'h44, 1, 'h55, 1, 'hA1, 1, 'hA2);
    // fill to full (R4 R5)
    cyc(1, 'h66, 1, 'h77, 0, 0, 0, 0);
    cyc(1, 'h88, 1, 'h99, 0, 0, 0, 0);
    cyc(1, 'hAA, 1, 'hBB, 0, 0, 0, 0);
    check("R5 full", full, 1);
    cyc(1, 'hCC, 1, 'hDD, 0, 0, 0, 0);  // ignored, ready low
    check("R4 push ignored when full", occupancy, DEPTH);
    // drain with double tags, pointers wrap
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, 'hB0 + 2*k, 1, 'hB1 + 2*k);
    idle();
    check("R5 empty", empty, 1);

    // R3 straddle off: lane 1 push ignored
    straddle_en = 1'b0;
    cyc(1, 'h01, 1, 'h02, 0, 0, 0, 0);
    check("R3 lane1 ignored", occupancy, 1);
    for (int k = 0; k < 7; k++) cyc(1, 'h10 + k, 0, 0, 0, 0, 0, 0);
    check("R4 rdy low at full single mode", req_rdy, 0);
    // R6 single push and pop when one slot in use
    for (int k = 0; k < 7; k++) cyc(0, 0, 0, 0, 1, 'hC0 + k, 0, 0);
    cyc(1, 'h5A, 0, 0, 1, 'hC7, 0, 0);
    cyc(0, 0, 0, 0, 1, 'hC8, 0, 0);
    idle();

    // R7 tag while empty
    cyc(0, 0, 0, 0, 1, 'hE0, 0, 0);
    idle(); idle();
    check("R9 sticky", proto_err, 1);
    do_reset();
    check("R9 reset clears error", proto_err, 0);

    // R8 lane1 without lane0, straddle on
    straddle_en = 1'b1;
    cyc(1, 'h61, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 'hE1);
    check("R8 lane1 alone ignored", occupancy, 1);
    // R7 both lanes with one outstanding
    cyc(0, 0, 0, 0, 1, 'hE2, 1, 'hE3);
    idle();
    do_reset();

    // R8 lane1 with straddle off
    straddle_en = 1'b0;
    cyc(1, 'h71, 0, 0, 0, 0, 0, 0);
    cyc(1, 'h72, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 'hF0, 1, 'hF1);
    idle();
    check("R8 one popped in single mode", occupancy, 1);

    check("R1 all lane0 pairs seen", exp0.size(), 0);
    check("R2 all lane1 pairs seen", exp1.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule